// File: doc/BRIEF.md
# Filtered Serial Byte Shifter

This block holds one byte for a two-wire, open-drain serial bus and moves it one bit at a time. The bus clock and data lines come in asynchronously. Each line first passes through a synchronizer and a small glitch filter. The block then works only from the filtered copies. A rising edge on the filtered clock line produces an internal shift strobe one system clock later, and every strobe moves the byte one place to the left.

When sending, the most significant bit is presented on the data line first. The block asks for the line to be pulled low whenever that bit is 0 and releases the line otherwise. When receiving, every strobe loads the filtered data level into bit 0, so after eight strobes the first bit on the bus sits in bit 7.

A processor loads and reads the byte over a plain write/read port. Loads are accepted only while the interface is enabled and no byte is in flight. The block counts bits, pulses a flag when a byte completes, and reports a sticky collision flag for loads attempted during a transfer. Bus conditions, addressing, acknowledge and arbitration are handled elsewhere.

Top module: `sbyte_shifter`

## Requirements
- R1: After reset, `rd_data` is 8'h00, and `busy`, `byte_done`, `wr_collision`, `sda_drive_low` and `bit_count` are all 0.
- R2: A `wr_en` pulse while `if_en`=1 and `busy`=0 loads `wr_data`, so it appears on `rd_data`. In transmit mode (`tx_mode`=1) such a load also sets `busy`.
- R3: A `wr_en` pulse while `if_en`=0 leaves `rd_data` unchanged and does not set `wr_collision`.
- R4: In transmit mode while `busy`=1, `sda_drive_low` is the inverse of `rd_data[7]`. Bits therefore leave MSB first, one per clock-line period, and the line is released when `busy`=0.
- R5: Each shift strobe shifts the byte left by one and loads the filtered data-line level into bit 0. In receive mode, after eight clock periods `rd_data` equals the eight received bits, with the first bit in bit 7.
- R6: A clock-line high pulse lasting one system clock is filtered out: no shift takes place and `bit_count` is unchanged.
- R7: Shifting happens only on rising edges of the filtered clock line. Falling edges, and data-line changes while the clock line is low, do not shift.
- R8: `bit_count` advances by one per shift. On the eighth shift it returns to 0, `busy` clears, and `byte_done` is high for exactly one cycle.
- R9: In receive mode, the first shift strobe of a byte sets `busy`.
- R10: A `wr_en` pulse while `if_en`=1 and `busy`=1 is ignored and sets `wr_collision`. The flag stays set until the next accepted load clears it.
- R11: While `if_en`=0, edges on the clock line do not shift the byte or advance `bit_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_en | input | 1 | Interface enable |
| tx_mode | input | 1 | 1 = transmit, 0 = receive |
| wr_en | input | 1 | Processor load strobe |
| wr_data | input | 8 | Byte to load |
| rd_data | output | 8 | Current shift register contents |
| scl_in | input | 1 | Raw bus clock line |
| sda_in | input | 1 | Raw bus data line |
| sda_drive_low | output | 1 | Request to pull the data line low |
| bit_count | output | 3 | Bits shifted in the current byte |
| busy | output | 1 | Byte transfer in progress |
| byte_done | output | 1 | One-cycle pulse on byte completion |
| wr_collision | output | 1 | Sticky flag for a load refused while busy |

## Verification
The bench builds the block with its default 8-bit byte and a two-stage synchronizer. That size lets it sweep all 256 byte values in both receive and transmit mode. In transmit mode the bench echoes the drive request back as the line level, so every sent byte must also reappear on `rd_data`. Directed cases then cover one-cycle clock glitches, data-line toggling while the clock is low, disabled operation, and loads refused during a transfer.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  typedef enum logic {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } dir_e;

  localparam int unsigned LINE_SCL = 0;
  localparam int unsigned LINE_SDA = 1;
  localparam int unsigned NUM_LINES = 2;
endpackage

// File: rtl/sbs_line_filter.sv
module sbs_line_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic        IDLE_LEVEL  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic filt
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   filt_q;
  logic                   filt_d;
  logic                   sync_out;

  assign sync_out = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= {SYNC_STAGES{IDLE_LEVEL}};
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
    end
  end

  always_comb begin
    filt_d = filt_q;
    if (sync_out == prev_q) begin
      filt_d = sync_out;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= IDLE_LEVEL;
      filt_q <= IDLE_LEVEL;
    end else begin
      prev_q <= sync_out;
      filt_q <= filt_d;
    end
  end

  assign filt = filt_q;

  // R6: a level that disagrees with the previous sample never reaches the output
  a_r6_filter_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_out != prev_q) |=> $stable(filt_q));
endmodule

// File: rtl/sbs_shift_strobe.sv
module sbs_shift_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic en,
  output logic shift_pulse
);
  logic scl_prev_q;
  logic pulse_q;
  logic pulse_d;

  always_comb begin
    pulse_d = en & scl_f & ~scl_prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev_q <= 1'b1;
      pulse_q    <= 1'b0;
    end else begin
      scl_prev_q <= scl_f;
      pulse_q    <= pulse_d;
    end
  end

  assign shift_pulse = pulse_q;

  // R7: the strobe follows a filtered rising edge and lasts one cycle
  a_r7_pulse_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    shift_pulse |-> ($past(scl_f) && !$past(scl_prev_q)));
  a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    shift_pulse |=> !shift_pulse);
endmodule

// File: rtl/sbs_shift_core.sv
module sbs_shift_core
  import sbs_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              if_en,
  input  dir_e              dir,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              shift_pulse,
  input  logic              sda_f,
  output logic [DATA_W-1:0] data,
  output logic [CNT_W-1:0]  count,
  output logic              busy,
  output logic              done,
  output logic              collision,
  output logic              drive_low
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] data_q, data_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              busy_q, busy_d;
  logic              done_q, done_d;
  logic              coll_q, coll_d;
  logic              wr_acc;
  logic              wr_rej;

  assign wr_acc = wr_en & if_en & ~busy_q;
  assign wr_rej = wr_en & if_en & busy_q;

  always_comb begin
    data_d = data_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = 1'b0;
    coll_d = coll_q;
    if (wr_acc) begin
      data_d = wr_data;
      cnt_d  = '0;
      busy_d = (dir == DIR_TX);
      coll_d = 1'b0;
    end else begin
      if (wr_rej) begin
        coll_d = 1'b1;
      end
      if (shift_pulse) begin
        data_d = {data_q[DATA_W-2:0], sda_f};
        if (cnt_q == LAST_BIT) begin
          cnt_d  = '0;
          busy_d = 1'b0;
          done_d = 1'b1;
        end else begin
          cnt_d  = cnt_q + 1'b1;
          busy_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      coll_q <= 1'b0;
    end else begin
      data_q <= data_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
      coll_q <= coll_d;
    end
  end

  assign data      = data_q;
  assign count     = cnt_q;
  assign busy      = busy_q;
  assign done      = done_q;
  assign collision = coll_q;
  assign drive_low = (dir == DIR_TX) & busy_q & ~data_q[DATA_W-1];

  // R5: each strobe moves the byte left and loads the filtered data level
  a_r5_shift_left: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_pulse && !wr_acc) |=> (data_q == {$past(data_q[DATA_W-2:0]), $past(sda_f)}));
  // R8: the completion pulse lasts one cycle and comes with busy low and count zero
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy_q && cnt_q == '0));
  // R10: a load refused during a transfer raises the flag
  a_r10_collision: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rej |=> coll_q);
  // R3 / R11: with the interface off and no pending strobe, the byte holds
  a_r3_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!if_en && !shift_pulse) |=> $stable(data_q));
  // R4: the line is only pulled low while a transmit byte is in flight
  a_r4_drive_tx_only: assert property (@(posedge clk) disable iff (!rst_n)
    drive_low |-> (dir == DIR_TX && busy_q));
endmodule

// File: rtl/sbyte_shifter.sv
module sbyte_shifter
  import sbs_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CNT_W       = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              if_en,
  input  logic              tx_mode,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_drive_low,
  output logic [CNT_W-1:0]  bit_count,
  output logic              busy,
  output logic              byte_done,
  output logic              wr_collision
);
  logic [1:0]           rst_sync_q;
  logic                 rst_int_n;
  logic [NUM_LINES-1:0] raw_lines;
  logic [NUM_LINES-1:0] filt_lines;
  logic                 shift_pulse;
  dir_e                 dir;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  assign raw_lines[LINE_SCL] = scl_in;
  assign raw_lines[LINE_SDA] = sda_in;
  assign dir = tx_mode ? DIR_TX : DIR_RX;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    sbs_line_filter #(
      .SYNC_STAGES (SYNC_STAGES),
      .IDLE_LEVEL  (1'b1)
    ) u_filt (
      .clk   (clk),
      .rst_n (rst_int_n),
      .raw   (raw_lines[g]),
      .filt  (filt_lines[g])
    );
  end

  sbs_shift_strobe u_strobe (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .scl_f       (filt_lines[LINE_SCL]),
    .en          (if_en),
    .shift_pulse (shift_pulse)
  );

  sbs_shift_core #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) u_core (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .if_en       (if_en),
    .dir         (dir),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .shift_pulse (shift_pulse),
    .sda_f       (filt_lines[LINE_SDA]),
    .data        (rd_data),
    .count       (bit_count),
    .busy        (busy),
    .done        (byte_done),
    .collision   (wr_collision),
    .drive_low   (sda_drive_low)
  );
endmodule

// File: tb/sbyte_shifter_bench.sv
module sbyte_shifter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PHASE      = 10;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       if_en, tx_mode, wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       scl_in, sda_in;
  logic       sda_drive_low;
  logic [2:0] bit_count;
  logic       busy, byte_done, wr_collision;

  int checks = 0;
  int fails  = 0;
  int done_pulses = 0;
  int done_wide = 0;
  int cycles = 0;
  logic done_prev = 1'b0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sbyte_shifter u_sbyte_shifter (
    .clk(clk), .rst_n(rst_n), .if_en(if_en), .tx_mode(tx_mode),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .scl_in(scl_in), .sda_in(sda_in), .sda_drive_low(sda_drive_low),
    .bit_count(bit_count), .busy(busy), .byte_done(byte_done),
    .wr_collision(wr_collision)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (byte_done) done_pulses <= done_pulses + 1;
    if (byte_done && done_prev) done_wide <= done_wide + 1;
    done_prev <= byte_done;
    if (cycles > WATCHDOG && !finished) begin
      finished = 1'b1;
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected below %0d", cycles, WATCHDOG);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic cpu_write(input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    idle(1);
  endtask

  // one clock-line period carrying bit b (SDA set while SCL low)
  task automatic bus_bit(input logic b);
    sda_in = b;
    idle(PHASE);
    scl_in = 1'b1;
    idle(PHASE);
    scl_in = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; if_en = 1'b0; tx_mode = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
    scl_in = 1'b0; sda_in = 1'b1;
    idle(4);
    rst_n = 1'b1;
    idle(PHASE);

    // R1 reset state
    check("R1 rd_data", rd_data, 8'h00);
    check("R1 busy", busy, 0);
    check("R1 byte_done", byte_done, 0);
    check("R1 wr_collision", wr_collision, 0);
    check("R1 sda_drive_low", sda_drive_low, 0);
    check("R1 bit_count", bit_count, 0);

    // R3 write while disabled is ignored
    cpu_write(8'hA5);
    check("R3 rd_data", rd_data, 8'h00);
    check("R3 wr_collision", wr_collision, 0);

    // R11 clock edges while disabled do not shift
    bus_bit(1'b1); bus_bit(1'b1);
    idle(PHASE);
    check("R11 bit_count", bit_count, 0);
    check("R11 rd_data", rd_data, 8'h00);

    if_en = 1'b1;
    idle(PHASE);
    // R2 accepted write in receive mode
    cpu_write(8'h3C);
    check("R2 rd_data", rd_data, 8'h3C);
    check("R2 busy rx", busy, 0);

    // R6 one-cycle clock glitch filtered
    @(negedge clk); scl_in = 1'b1;
    @(negedge clk); scl_in = 1'b0;
    idle(PHASE);
    check("R6 bit_count", bit_count, 0);
    check("R6 rd_data", rd_data, 8'h3C);

    // R7 data toggling while clock low does not shift
    for (int i = 0; i < 6; i++) begin
      sda_in = ~sda_in; idle(PHASE);
    end
    check("R7 bit_count", bit_count, 0);
    check("R7 rd_data", rd_data, 8'h3C);

    // R5 / R8 / R9 receive sweep over all byte values
    for (int v = 0; v < 256; v++) begin
      for (int i = 0; i < 8; i++) begin
        bus_bit(v[7-i]);
        if (i < 7) begin
          check("R8 bit_count rx", bit_count, i + 1);
          if (i == 0) check("R9 busy after first bit", busy, 1);
        end
      end
      idle(PHASE);
      check("R5 received byte", rd_data, v);
      check("R8 busy clear rx", busy, 0);
      check("R8 bit_count wrap rx", bit_count, 0);
    end
    check("R8 done pulses rx", done_pulses, 256);

    // R4 transmit sweep, line level echoes the drive request
    tx_mode = 1'b1;
    idle(2);
    for (int v = 0; v < 256; v++) begin
      cpu_write(8'(v));
      check("R2 busy tx", busy, 1);
      for (int i = 0; i < 8; i++) begin
        check("R4 drive level", sda_drive_low, !v[7-i]);
        bus_bit(!sda_drive_low);
      end
      idle(PHASE);
      check("R4 echoed byte", rd_data, v);
      check("R4 released", sda_drive_low, 0);
      check("R8 busy clear tx", busy, 0);
    end
    check("R8 done pulses total", done_pulses, 512);
    check("R8 done width", done_wide, 0);

    // R10 write during transfer is refused and flagged
    cpu_write(8'h96);
    bus_bit(!sda_drive_low);
    bus_bit(!sda_drive_low);
    cpu_write(8'hFF);
    check("R10 collision set", wr_collision, 1);
    for (int i = 2; i < 8; i++) bus_bit(!sda_drive_low);
    idle(PHASE);
    check("R10 byte kept", rd_data, 8'h96);
    check("R10 collision sticky", wr_collision, 1);
    cpu_write(8'h5A);
    check("R10 collision cleared", wr_collision, 0);
    check("R10 new load", rd_data, 8'h5A);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule